// File: doc/BRIEF.md
# Type-0 Configuration Address Translator

This block sits behind a processor-side window that reaches configuration space on a PCI segment. Each access that lands in the window presents a 16-bit offset, a 32-bit mapping register value and the local bus number. The block joins the mapping register's low half, as the upper 16 bits, with the offset to form a 32-bit intermediate address. Bits [31:11] of that address are a one-hot device-select field. The index of its lowest set bit becomes the device number. The function and the dword-aligned register offset are taken directly from the lower bits. The result is a standard type-0 configuration address with its enable bit set.

One cycle after a request strobe, the block reports one of three outcomes, each lasting a single cycle. A granted translation comes with the address and with pulses that clear the host's received-master-abort and received-target-abort status bits. A refused request, marked by the type-1 flag in the mapping register, produces an all-ones read fill sized to the access width; a refused write is simply dropped. A select fault means the select field held no set bit.

A small state machine holds the outcome, using the states ST_IDLE, ST_GRANT, ST_REFUSE and ST_FAULT. A request moves the machine from any state to exactly one result state. The choice follows a fixed priority: the type-1 flag first, then an empty select field, and otherwise a grant. A cycle without a request returns the machine to ST_IDLE.

Top module: `cfgx_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: Each request strobe sampled on a clock edge yields exactly one outcome flag (xlate_ok_o, refuse_o or sel_err_o), high for exactly the following cycle. With no request, all three flags stay low.
- R3: When bit 16 of map_reg_i is set, the request is refused (refuse_o). This takes priority over the select check. No grant, no fault and no clear pulse results, and cfg_addr_o stays zero.
- R4: For a refused read (wr_i=0), rd_fill_o holds all ones over the access width, encoded by size_i as 0=1 byte (0x000000FF), 1=2 bytes, 2=3 bytes, 3=4 bytes (0xFFFFFFFF). For a refused write, rd_fill_o is zero. Outside a refusal, rd_fill_o is zero.
- R5: The intermediate address is {map_reg_i[15:0], acc_addr_i[15:0]}. Its bits [31:11] form the device-select field.
- R6: The device number is the index of the lowest set bit of the select field. Intermediate bit 11 gives device 0, and any higher set bits are ignored.
- R7: On a grant, cfg_addr_o has bit 31 = 1, bits [30:24] = 0, [23:16] = bus_num_i, [15:11] = device, [10:8] = intermediate bits [10:8], [7:2] = intermediate bits [7:2], and [1:0] = 0. Outside a grant, cfg_addr_o is zero.
- R8: A type-0 request whose select field is zero raises sel_err_o, with no grant and no clear pulse.
- R9: Both clear pulses are high in exactly the grant cycle, for reads and writes alike.
- R10: Requests on consecutive cycles each produce their own outcome on consecutive cycles.
- R11: At most one of the three outcome flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width in bytes minus one |
| acc_addr_i | input | 16 | Offset of the access inside the window |
| map_reg_i | input | 32 | Mapping register: [15:0] upper address, [16] type-1 flag |
| bus_num_i | input | 8 | Local bus number |
| cfg_addr_o | output | 32 | Translated configuration address (grant cycle only) |
| xlate_ok_o | output | 1 | Grant outcome |
| refuse_o | output | 1 | Type-1 refusal outcome |
| sel_err_o | output | 1 | Empty select field outcome |
| rd_fill_o | output | 32 | All-ones read fill on a refused read |
| clr_mabort_o | output | 1 | Clear received-master-abort pulse |
| clr_tabort_o | output | 1 | Clear received-target-abort pulse |

## Verification
On every cycle, the assertions check several properties. The outcome flags must be mutually exclusive. Each flag must trace back to a request one cycle earlier, and a request must always produce one. A refusal must trace back to a set type-1 flag, and a fault to an empty select field. A grant must carry the enable bit, and the encoder must pick a set bit with nothing set below it. Only the bench's scenarios can show the full translated address, the device number for each select position, the masking of the low offset bits, the width-dependent fill, the refusal winning over an empty field, and back-to-back sequencing.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REFUSE = 2'd2,
        ST_FAULT  = 2'd3
    } cfgx_state_e;
endpackage

// File: rtl/cfgx_lsb_enc.sv
module cfgx_lsb_enc #(
    parameter int SEL_W = 21,
    localparam int IDX_W = $clog2(SEL_W)
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |sel_i;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel_i[i]) idx_o = IDX_W'(i);
        end
    end

    always_comb begin
        if (any_o) begin
            // R6
            enc_lowest_chk: assert (sel_i[idx_o] &&
                ((sel_i & ((SEL_W'(1) << idx_o) - SEL_W'(1))) == '0));
        end
    end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
    import cfgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic type1_i,
    input  logic sel_any_i,
    output logic grant_o,
    output logic refuse_o,
    output logic fault_o
);
    cfgx_state_e state_q, state_d;

    always_comb begin
        if (!req_i)          state_d = ST_IDLE;
        else if (type1_i)    state_d = ST_REFUSE;
        else if (!sel_any_i) state_d = ST_FAULT;
        else                 state_d = ST_GRANT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_o  = 1'b0;
        refuse_o = 1'b0;
        fault_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_GRANT:  grant_o  = 1'b1;
            ST_REFUSE: refuse_o = 1'b1;
            ST_FAULT:  fault_o  = 1'b1;
        endcase
    end

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, refuse_o, fault_o}));
    // R2
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (grant_o || refuse_o || fault_o));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(grant_o || refuse_o || fault_o));
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top #(
    parameter int ACC_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int BUS_W    = 8,
    parameter int SEL_LSB  = 11,
    parameter int TYPE_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [1:0]        size_i,
    input  logic [ACC_W-1:0]  acc_addr_i,
    input  logic [ADDR_W-1:0] map_reg_i,
    input  logic [BUS_W-1:0]  bus_num_i,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic              xlate_ok_o,
    output logic              refuse_o,
    output logic              sel_err_o,
    output logic [ADDR_W-1:0] rd_fill_o,
    output logic              clr_mabort_o,
    output logic              clr_tabort_o
);
    localparam int SEL_W = ADDR_W - SEL_LSB;
    localparam int DEV_W = $clog2(SEL_W);
    localparam int PAD_W = ADDR_W - 1 - BUS_W - DEV_W - 3 - 8;

    logic [ADDR_W-1:0] inter;
    logic [SEL_W-1:0]  sel;
    logic [DEV_W-1:0]  dev_idx;
    logic              sel_any;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] fill_d, fill_q;

    assign inter = {map_reg_i[ADDR_W-ACC_W-1:0], acc_addr_i};
    assign sel   = inter[ADDR_W-1:SEL_LSB];

    cfgx_lsb_enc #(.SEL_W(SEL_W)) enc_i (
        .sel_i (sel),
        .idx_o (dev_idx),
        .any_o (sel_any)
    );

    cfgx_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .type1_i   (map_reg_i[TYPE_BIT]),
        .sel_any_i (sel_any),
        .grant_o   (xlate_ok_o),
        .refuse_o  (refuse_o),
        .fault_o   (sel_err_o)
    );

    assign addr_d = {1'b1, {PAD_W{1'b0}}, bus_num_i, dev_idx,
                     inter[10:8], inter[7:2], 2'b00};
    assign fill_d = wr_i ? '0 : ({ADDR_W{1'b1}} >> (8 * (3 - int'(size_i))));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fill_q <= '0;
        end else if (req_i) begin
            addr_q <= addr_d;
            fill_q <= fill_d;
        end
    end

    assign cfg_addr_o   = xlate_ok_o ? addr_q : '0;
    assign rd_fill_o    = refuse_o ? fill_q : '0;
    assign clr_mabort_o = xlate_ok_o;
    assign clr_tabort_o = xlate_ok_o;

    // R3
    refuse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_o |-> $past(map_reg_i[TYPE_BIT]));
    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_o |-> ($past(sel) == '0 && !$past(map_reg_i[TYPE_BIT])));
    // R7
    grant_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_ok_o |-> (cfg_addr_o[ADDR_W-1] && cfg_addr_o[1:0] == 2'b00));
    // R9
    grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mabort_o |-> ($past(req_i) && !$past(map_reg_i[TYPE_BIT])));
endmodule

// File: tb/cfgx_top_tb_top.sv
module cfgx_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [15:0] acc_addr_i = '0;
    logic [31:0] map_reg_i = '0;
    logic [7:0]  bus_num_i = '0;
    logic [31:0] cfg_addr_o, rd_fill_o;
    logic        xlate_ok_o, refuse_o, sel_err_o, clr_mabort_o, clr_tabort_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [97:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    cfgx_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .size_i(size_i),
        .acc_addr_i(acc_addr_i), .map_reg_i(map_reg_i), .bus_num_i(bus_num_i),
        .cfg_addr_o(cfg_addr_o), .xlate_ok_o(xlate_ok_o), .refuse_o(refuse_o),
        .sel_err_o(sel_err_o), .rd_fill_o(rd_fill_o),
        .clr_mabort_o(clr_mabort_o), .clr_tabort_o(clr_tabort_o)
    );

    function automatic logic [97:0] model(input logic rq, input logic wr,
            input logic [1:0] sz, input logic [15:0] acc,
            input logic [31:0] mp, input logic [7:0] bus);
        logic [31:0] im, addr, fill;
        logic [20:0] sl;
        logic ok, rf, er;
        int dev;
        ok = 0; rf = 0; er = 0; addr = 0; fill = 0;
        if (rq) begin
            im = {mp[15:0], acc};
            sl = im[31:11];
            if (mp[16]) begin
                rf = 1;
                if (!wr) begin
                    fill = 0;
                    for (int b = 0; b <= int'(sz); b++) fill = fill | (32'hFF << (8*b));
                end
            end else if (sl == 0) begin
                er = 1;
            end else begin
                dev = 0;
                while (!sl[dev]) dev++;
                ok = 1;
                addr = 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11)
                     | (32'(im[10:8]) << 8) | 32'(im[7:0] & 8'hFC);
            end
        end
        return {addr, fill, ok, rf, er, ok, ok, 28'd0};
    endfunction

    task automatic compare(input logic [97:0] e, input string tag);
        logic [97:0] a;
        a = {cfg_addr_o, rd_fill_o, xlate_ok_o, refuse_o, sel_err_o,
             clr_mabort_o, clr_tabort_o, 28'd0};
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: addr=%h fill=%h ok/rf/er/cm/ct=%b expected addr=%h fill=%h ok/rf/er/cm/ct=%b",
                     tag, a[97:66], a[65:34], a[33:29], e[97:66], e[65:34], e[33:29]);
        end
    endtask

    // at a negedge: check the previous cycle's expectation, then drive new inputs
    task automatic step(input logic rq, input logic wr, input logic [1:0] sz,
            input logic [15:0] acc, input logic [31:0] mp, input logic [7:0] bus,
            input string tag);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        req_i = rq; wr_i = wr; size_i = sz; acc_addr_i = acc;
        map_reg_i = mp; bus_num_i = bus;
        exp_q.push_back(model(rq, wr, sz, acc, mp, bus));
        tag_q.push_back(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs zero in reset, even with a request presented
        req_i = 1'b1; acc_addr_i = 16'h0800;
        repeat (3) begin
            @(negedge clk);
            compare('0, "R1 reset");
        end
        req_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare('0, "R1 after reset");

        // R5 R6 R7: lowest select bit 11 -> device 0, fields from offset
        step(1, 0, 3, 16'h0A7C, 32'h0000_0000, 8'h00, "R7 dev0");
        step(0, 0, 0, 16'h0000, 32'h0000_0000, 8'h00, "R2 idle");
        // R6: intermediate bit 17 -> device 6, from map upper half
        step(1, 1, 1, 16'h0544, 32'h0000_0002, 8'h3C, "R6 bit17");
        // R6: only bit 31 set -> device 20
        step(1, 0, 0, 16'h0010, 32'h0000_8000, 8'hFF, "R6 top bit");
        // R6: several bits set, lowest wins; R7 low offset bits masked
        step(1, 0, 2, 16'hE3FF, 32'h0000_F0F0, 8'h5A, "R6 lowest wins");
        // R10: back-to-back mixed outcomes
        step(1, 0, 3, 16'h1000, 32'h0001_0000, 8'h01, "R10 refuse in burst");
        step(1, 0, 3, 16'h0004, 32'h0000_0000, 8'h01, "R8 fault in burst");
        step(1, 1, 3, 16'h2208, 32'h0000_0000, 8'h02, "R10 grant in burst");
        step(0, 0, 0, 16'h0000, 32'h0000_0000, 8'h00, "R2 idle");
        // R4: refused reads of each width, then a refused write
        step(1, 0, 0, 16'h0800, 32'h0001_0000, 8'h00, "R4 fill 1B");
        step(1, 0, 1, 16'h0800, 32'h0001_0000, 8'h00, "R4 fill 2B");
        step(1, 0, 2, 16'h0800, 32'h0001_0000, 8'h00, "R4 fill 3B");
        step(1, 0, 3, 16'h0800, 32'h0001_0000, 8'h00, "R4 fill 4B");
        step(1, 1, 3, 16'h0800, 32'h0001_0000, 8'h00, "R4 write dropped");
        // R3: type-1 with empty select still refused, not faulted
        step(1, 0, 3, 16'h0000, 32'h0001_0000, 8'h00, "R3 priority");
        step(0, 0, 0, 16'h0000, 32'h0001_0000, 8'h00, "R2 idle");
        // R8: empty select on type-0, read and write
        step(1, 0, 3, 16'h07FC, 32'h0000_0000, 8'h77, "R8 read");
        step(1, 1, 0, 16'h0000, 32'hFFFE_0000, 8'h77, "R8 write");
        // R9: grant on write and read both pulse clears
        step(1, 1, 3, 16'h4300, 32'h0000_0000, 8'h10, "R9 write grant");
        step(1, 0, 3, 16'h8000, 32'h0000_0000, 8'h10, "R9 read grant");
        // R11: walk every select position
        for (int p = 11; p < 32; p++) begin
            logic [31:0] im;
            im = 32'd1 << p;
            step(1, 0, 3, im[15:0] | 16'h0024, {16'h0, im[31:16]}, 8'(p), "R11 sweep");
        end
        step(0, 0, 0, 16'h0000, 32'h0000_0000, 8'h00, "R2 idle");
        step(0, 0, 0, 16'h0000, 32'h0000_0000, 8'h00, "R2 final");
        @(negedge clk);
        while (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule